// File: doc/BRIEF.md
# TMDS Link Transmitter (Encode and Serialize)

This block turns a stream of 24-bit RGB pixels into four serial lanes: three data lanes and a clock lane. Each 8-bit colour byte goes through two steps. First it is rewritten into a 9-bit word with few internal transitions. Then it is sent either as is or with its low eight bits inverted, whichever keeps the running DC balance of the lane close to zero. The two choices are recorded in bits 8 and 9, so a receiver can restore the byte. While data-enable is low, each lane sends one of four fixed control tokens, chosen by two control bits. On the blue lane those two bits are the horizontal and vertical sync.

The block runs entirely on the 10x bit clock. A one-cycle pixel enable marks the bit-clock edge on which a pixel is taken. The pixel enable must pulse once every ten bit clocks. On the following edge, the encoded symbol of each lane is loaded into a shift register and sent least significant bit first. The clock lane sends five low bits followed by five high bits, aligned to the same symbol boundary.

Top module: `tmds_link_tx`

## Requirements
- R1: While reset is held, and after it is released until the first pixel enable, all four lanes are low and every lane's running disparity is zero.
- R2: A pixel is taken on a rising edge where `pix_ce_i` is high, and `pix_ce_i` pulses once every 10 cycles. Bit k (k = 0..9) of that pixel's symbol is on its lane after the (k+1)-th following rising edge. Lane 0 is blue (`rgb_i[7:0]`), lane 1 is green (`rgb_i[15:8]`), lane 2 is red (`rgb_i[23:16]`).
- R3: Bit 0 of the transition-minimized word equals data bit 0. If the byte has fewer than four ones, or exactly four ones with bit 0 set, each later bit k is the XOR of the previous word bit and data bit k, and symbol bit 8 is 1. Otherwise each later bit is the XNOR of the same two bits, and bit 8 is 0.
- R4: The low eight bits of the transition-minimized word have at most 3 transitions between neighbouring bits. For example, 0x55, which has 7 transitions, comes out with at most 3.
- R5: Let N be the number of ones in the low eight bits of the transition-minimized word, and let D be the lane's disparity before the symbol. If D is 0 or N is 4, bit 9 is the inverse of bit 8. Otherwise bit 9 is 1 exactly when (D > 0 and N > 4) or (D < 0 and N < 4). When bit 9 is 1, symbol bits 7..0 are the inverse of the word.
- R6: The running disparity of a lane is the sum of (ones minus zeros) over all 10-bit data symbols sent since the last blanking pixel. It stays within -8..+8. Every pixel with data-enable low resets it to zero.
- R7: With data-enable low, a lane sends the token 0x354, 0x0AB, 0x154 or 0x2AB for control value {c1,c0} = 00, 01, 10 or 11. For blue, c0 = `hsync_i` and c1 = `vsync_i`. For green and red, c1 and c0 are bits 1 and 0 of `ctl_g_i` and `ctl_r_i`.
- R8: In every symbol period the clock lane sends 0,0,0,0,0,1,1,1,1,1 in time order, starting on the same edge as bit 0 of the data lanes.
- R9: Decoding a data symbol recovers the input byte. Undo the inversion if bit 9 is set. Then undo the XOR or XNOR chain that bit 8 selects.
- R10: A long run of identical all-ones or all-zeros bytes includes symbols with bit 9 set, so the line stays balanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 10x bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_ce_i | input | 1 | Pixel enable, one cycle in ten |
| de_i | input | 1 | Data enable (high for active video) |
| rgb_i | input | 24 | Pixel: red [23:16], green [15:8], blue [7:0] |
| hsync_i | input | 1 | Blue-lane control bit c0 |
| vsync_i | input | 1 | Blue-lane control bit c1 |
| ctl_g_i | input | 2 | Green-lane control bits {c1,c0} |
| ctl_r_i | input | 2 | Red-lane control bits {c1,c0} |
| tmds_d_o | output | 3 | Serial data lanes: [0] blue, [1] green, [2] red |
| tmds_clk_o | output | 1 | Serial clock-pattern lane |

## Verification
Results are due at fixed edges after a pixel is taken. The encoded symbol is registered on the sampling edge itself. The shift register loads on the next edge. Bit k is therefore valid on a lane after edge k+1, so bit 9 of one pixel falls on the same edge that takes the next pixel.

The bench drives inputs on falling edges and keeps the pixel enable at exactly one pulse per ten cycles. It reads every lane on each falling edge into a per-lane bit buffer. Bits 0 to 8 of a pixel arrive within its own ten-cycle slot; bit 9 arrives in the first cycle of the next slot. Each symbol is checked only once bit 9 is in, against a running disparity that the bench keeps itself from the symbols it has received.

// File: rtl/tmds_pkg.sv
package tmds_pkg;
  localparam int unsigned DW     = 8;        // colour component width
  localparam int unsigned SW     = DW + 2;   // symbol width = serial ratio
  localparam int unsigned NCH    = 3;        // data lanes
  localparam int unsigned DISP_W = 6;        // signed disparity width
  localparam int          DISP_LIM = 8;

  typedef logic [SW-1:0] sym_t;
  typedef logic [DW-1:0] byte_t;

  // time order 0000011111 when sent lsb first
  localparam sym_t CLK_PAT = 10'b1111100000;

  function automatic sym_t ctl_token(input logic [1:0] c);
    unique case (c)
      2'b00:   ctl_token = 10'h354;
      2'b01:   ctl_token = 10'h0AB;
      2'b10:   ctl_token = 10'h154;
      default: ctl_token = 10'h2AB;
    endcase
  endfunction

  function automatic int unsigned edges_in(input byte_t v);
    int unsigned n;
    n = 0;
    for (int k = 1; k < DW; k++) n += (v[k] != v[k-1]) ? 1 : 0;
    return n;
  endfunction
endpackage

// File: rtl/tmds_tm_stage.sv
module tmds_tm_stage
  import tmds_pkg::*;
(
  input  byte_t         d_i,
  output logic [DW:0]   qm_o
);
  localparam int unsigned HALF = DW / 2;

  logic [DW-1:0] chain;
  logic          use_xnor;
  int unsigned   n1;

  always_comb begin
    n1       = $countones(d_i);
    use_xnor = (n1 > HALF) || ((n1 == HALF) && !d_i[0]);
  end

  assign chain[0] = d_i[0];
  for (genvar k = 1; k < DW; k++) begin : g_chain
    assign chain[k] = use_xnor ? ~(chain[k-1] ^ d_i[k]) : (chain[k-1] ^ d_i[k]);
  end

  assign qm_o = {~use_xnor, chain};
endmodule

// File: rtl/tmds_chan_enc.sv
module tmds_chan_enc
  import tmds_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       de_i,
  input  byte_t      d_i,
  input  logic [1:0] c_i,
  output sym_t       sym_o
);
  typedef logic signed [DISP_W-1:0] disp_t;
  localparam disp_t ZERO = '0;
  localparam disp_t TWO  = disp_t'(2);
  localparam disp_t HALF = disp_t'(DW / 2);
  localparam disp_t LIM  = disp_t'(DISP_LIM);

  logic [DW:0] qm;
  disp_t       disp_q, disp_n, ones_s, diff;
  sym_t        sym_q, sym_n;
  logic        qm_x;

  tmds_tm_stage u_tm (.d_i(d_i), .qm_o(qm));

  assign qm_x = qm[DW];

  always_comb begin
    ones_s = disp_t'($countones(qm[DW-1:0]));
    diff   = (ones_s - HALF) <<< 1;
    if (disp_q == ZERO || ones_s == HALF) begin
      sym_n  = {~qm_x, qm_x, qm_x ? qm[DW-1:0] : ~qm[DW-1:0]};
      disp_n = qm_x ? disp_q + diff : disp_q - diff;
    end else if ((disp_q > ZERO && ones_s > HALF) ||
                 (disp_q < ZERO && ones_s < HALF)) begin
      sym_n  = {1'b1, qm_x, ~qm[DW-1:0]};
      disp_n = disp_q - diff + (qm_x ? TWO : ZERO);
    end else begin
      sym_n  = {1'b0, qm_x, qm[DW-1:0]};
      disp_n = disp_q + diff - (qm_x ? ZERO : TWO);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q  <= '0;
      disp_q <= ZERO;
    end else if (ce_i) begin
      if (de_i) begin
        sym_q  <= sym_n;
        disp_q <= disp_n;
      end else begin
        sym_q  <= ctl_token(c_i);
        disp_q <= ZERO;
      end
    end
  end

  assign sym_o = sym_q;

  a_r6_disp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_q <= LIM) && (disp_q >= -LIM));

  a_r6_blank_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !de_i |=> disp_q == ZERO);

  a_r7_token_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !de_i |=> (sym_q == ctl_token(2'b00)) || (sym_q == ctl_token(2'b01)) ||
                      (sym_q == ctl_token(2'b10)) || (sym_q == ctl_token(2'b11)));

  a_r4_trans_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && de_i |=> edges_in(sym_q[SW-1] ? ~sym_q[DW-1:0] : sym_q[DW-1:0]) <= 3);
endmodule

// File: rtl/tmds_serializer.sv
module tmds_serializer
  import tmds_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  sym_t word_i,
  output logic ser_o
);
  sym_t sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (ld_i) sh_q <= word_i;
    else           sh_q <= sh_q >> 1;
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/tmds_link_tx.sv
module tmds_link_tx
  import tmds_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_ce_i,
  input  logic              de_i,
  input  logic [NCH*DW-1:0] rgb_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [1:0]        ctl_g_i,
  input  logic [1:0]        ctl_r_i,
  output logic [NCH-1:0]    tmds_d_o,
  output logic              tmds_clk_o
);
  logic [1:0] chan_c [NCH];
  sym_t       chan_sym [NCH];
  logic       ld_q;

  assign chan_c[0] = {vsync_i, hsync_i};
  assign chan_c[1] = ctl_g_i;
  assign chan_c[2] = ctl_r_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ld_q <= 1'b0;
    else         ld_q <= pix_ce_i;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    tmds_chan_enc u_enc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ce_i  (pix_ce_i),
      .de_i  (de_i),
      .d_i   (rgb_i[ch*DW +: DW]),
      .c_i   (chan_c[ch]),
      .sym_o (chan_sym[ch])
    );
    tmds_serializer u_ser (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (ld_q),
      .word_i(chan_sym[ch]),
      .ser_o (tmds_d_o[ch])
    );
  end

  tmds_serializer u_clk_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ld_q),
    .word_i(CLK_PAT),
    .ser_o (tmds_clk_o)
  );

  a_r2_ce_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ce_i |=> !pix_ce_i);

  a_r8_clk_low_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_q |=> !tmds_clk_o);
endmodule

// File: tb/tmds_link_tx_test.sv
module tmds_link_tx_test;
  logic        clk = 1'b0, rst_n = 1'b0, pix_ce = 1'b0, de = 1'b0;
  logic        hs = 1'b0, vs = 1'b0;
  logic [23:0] rgb = '0;
  logic [1:0]  cg = '0, cr = '0;
  logic [2:0]  d_o;
  logic        clk_o;

  tmds_link_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_ce_i(pix_ce), .de_i(de), .rgb_i(rgb),
    .hsync_i(hs), .vsync_i(vs), .ctl_g_i(cg), .ctl_r_i(cr),
    .tmds_d_o(d_o), .tmds_clk_o(clk_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, inv_cnt = 0;
  bit done = 0;
  bit [9:0] cap [4];
  bit       pv = 0, pde = 0;
  bit [7:0] pdat [3];
  bit [1:0] pctl [3];
  int       disp [3] = '{0, 0, 0};

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [9:0] tok(bit [1:0] c);
    case (c)
      2'b00: return 10'h354;
      2'b01: return 10'h0AB;
      2'b10: return 10'h154;
      default: return 10'h2AB;
    endcase
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic grab(int k);
    for (int ch = 0; ch < 3; ch++) cap[ch][k] = d_o[ch];
    cap[3][k] = clk_o;
  endtask

  task automatic verify_prev();
    chk(cap[3] == 10'b1111100000, "R8 clock lane", cap[3], 10'h3E0);
    for (int ch = 0; ch < 3; ch++) begin
      bit [9:0] sym;
      sym = cap[ch];
      if (pde) begin
        bit [7:0] qm, dec;
        int ones, qo, tr;
        bit exp8, expinv;
        qm = sym[9] ? ~sym[7:0] : sym[7:0];
        dec[0] = qm[0];
        for (int k = 1; k < 8; k++) dec[k] = sym[8] ? (qm[k] ^ qm[k-1]) : ~(qm[k] ^ qm[k-1]);
        chk(dec == pdat[ch], "R9 round trip (R2 timing)", dec, pdat[ch]);
        ones = $countones(pdat[ch]);
        exp8 = (ones < 4) || (ones == 4 && pdat[ch][0]);
        chk(sym[8] == exp8, "R3 bit8", sym[8], exp8);
        tr = 0;
        for (int k = 1; k < 8; k++) tr += (qm[k] != qm[k-1]) ? 1 : 0;
        chk(tr <= 3, "R4 transitions", tr, 3);
        qo = $countones(qm);
        if (disp[ch] == 0 || qo == 4) expinv = !sym[8];
        else expinv = (disp[ch] > 0 && qo > 4) || (disp[ch] < 0 && qo < 4);
        chk(sym[9] == expinv, "R5 inversion", sym[9], expinv);
        inv_cnt += sym[9];
        disp[ch] += 2 * $countones(sym) - 10;
        chk(disp[ch] <= 8 && disp[ch] >= -8, "R6 disparity", disp[ch], 8);
      end else begin
        chk(sym == tok(pctl[ch]), "R7 token", sym, tok(pctl[ch]));
        disp[ch] = 0;
      end
    end
  endtask

  task automatic slot(bit d, bit [23:0] px, bit h, bit v, bit [1:0] g, bit [1:0] r);
    de = d; rgb = px; hs = h; vs = v; cg = g; cr = r; pix_ce = 1'b1;
    @(negedge clk);
    pix_ce = 1'b0;
    grab(9);
    if (pv) verify_prev();
    pv = 1; pde = d;
    pdat[0] = px[7:0]; pdat[1] = px[15:8]; pdat[2] = px[23:16];
    pctl[0] = {v, h}; pctl[1] = g; pctl[2] = r;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      grab(k);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({d_o, clk_o} == 4'b0, "R1 lanes in reset", {d_o, clk_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({d_o, clk_o} == 4'b0, "R1 lanes after reset", {d_o, clk_o}, 0);
    @(negedge clk);

    // control tokens on every lane
    for (int i = 0; i < 4; i++) slot(0, 24'h0, i[0], i[1], 2'(i), ~2'(i));

    // full byte sweep with blanking interleaved
    for (int v = 0; v < 256; v++) begin
      bit [7:0] b, g, r;
      r = 8'(v); g = 8'(v) ^ 8'hA5; b = 8'(v * 37 + 11);
      slot(1, {r, g, b}, 0, 0, 0, 0);
      if (v % 32 == 31) slot(0, 24'h0, v[5], v[6], 2'(v >> 5), 2'(v >> 6));
    end

    // alternating words
    for (int i = 0; i < 8; i++) slot(1, i[0] ? 24'hAA55AA : 24'h55AA55, 0, 0, 0, 0);
    slot(0, 24'h0, 1, 1, 3, 3);

    // R10: long constant runs
    inv_cnt = 0;
    for (int i = 0; i < 16; i++) slot(1, 24'hFFFFFF, 0, 0, 0, 0);
    slot(0, 24'h0, 0, 0, 0, 0);
    chk(inv_cnt > 0, "R10 ones run inverted", inv_cnt, 1);
    inv_cnt = 0;
    for (int i = 0; i < 16; i++) slot(1, 24'h000000, 0, 0, 0, 0);
    slot(0, 24'h0, 1, 0, 1, 2);
    chk(inv_cnt > 0, "R10 zeros run inverted", inv_cnt, 1);

    slot(0, 24'h0, 0, 0, 0, 0);
    done = 1;
    summary();
  end
endmodule